// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block sits on the host side of a raw 8-bit NAND flash bus. A client hands it one request at a time: an operation code, a row (page) address, a destination row for copy-back, a column address and a byte count. The sequencer expands the request into the full train of command, address and data bus cycles. Where the flash goes busy, it waits on the ready/busy line. After a program or erase it reads the status byte and ends with a one-cycle done pulse that carries a result code.

Write data enters through a byte-wide valid/ready stream, and read data leaves through another one. Setup time and strobe width of every bus cycle come from configuration inputs. A further configuration input bounds how long a busy wait may last. A page program is split into three requests: open a load, add optional column jumps, then commit. This lets a client scatter data over a page before the single commit.

Top module: `nand_seq`

## Requirements
- R1: After reset CE#, WE# and RE# are high, CLE, ALE and the I/O drive enable are low, done is low and req_ready is high.
- R2: Request op 0 (page read) issues command 00h, then the address bytes column low, column high (column bits 11:8), row low, row high, then command 30h. It waits for ready and then makes req_len RE# cycles. Each byte leaves on rd_data in order, held stable while rd_valid is high and rd_ready low.
- R3: Request op 1 (load open) issues 80h and the same four address bytes, then writes req_len bytes taken from the write stream, with no confirm command. It leaves a program load open.
- R4: Request op 2 (column jump) issues 85h, column low, column high, then req_len write-stream bytes. It is rejected when no load is open.
- R5: Request op 3 (commit) issues 10h, waits for ready, issues 70h and reads one status byte. It closes the load and is rejected when no load is open, so no data can follow a commit.
- R6: Request op 4 (block erase) issues 60h, row low, row high, D0h in that order, waits for ready, then issues 70h and reads the status byte.
- R7: Request op 5 (copy-back) issues 00h, two zero column bytes, source row low and high, then 35h. After ready it issues 85h, two zero column bytes, destination row low and high, then 10h. After ready again it issues 70h and reads status. No data cycle occurs.
- R8: Request op 6 (status) issues 70h and delivers one status byte on the read stream. A following page read still starts with 00h, which leaves status mode.
- R9: done is high for exactly one cycle per request, with done_code 0 for pass, 1 for fail (status bit 0 set after commit, erase or copy-back), 2 for timeout and 3 for reject.
- R10: A read, load-open or column-jump request whose column exceeds 2111, or any request with op 7, is rejected: no bus cycle occurs and CE# stays high.
- R11: When ready/busy is still low after cfg_timeout cycles of a wait (cfg_timeout must exceed 4), the request ends with timeout and CE# returns high.
- R12: In a command, address or write cycle, CLE, ALE and the data are presented cfg_setup+1 cycles before WE# falls. WE# or RE# stays low for cfg_pulse+1 cycles, and the I/O data is stable while WE# is low. WE# and RE# are never low together, and CLE and ALE are never high together.
- R13: CE# is low while an accepted request runs and high whenever req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 3 | Operation code (0..6, 7 invalid) |
| req_row | input | 16 | Page address (source row for copy-back) |
| req_dst_row | input | 16 | Destination row for copy-back |
| req_col | input | 12 | Column address |
| req_len | input | 12 | Data byte count |
| cfg_setup | input | 4 | Setup cycles minus one before each strobe |
| cfg_pulse | input | 4 | Strobe low cycles minus one |
| cfg_timeout | input | 16 | Busy wait limit in cycles |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte taken |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Read stream consumer ready |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | Result: pass, fail, timeout, reject |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus byte driven to flash |
| nand_io_oe | output | 1 | Bus drive enable |
| nand_io_in | input | 8 | Bus byte from flash |
| nand_rb | input | 1 | Ready (high) / busy (low) |

## Verification
A wrong step index or operation latch shows up at the next rising WE# edge as an unexpected command or address byte. A model of the flash logs every latched byte, so the fault is visible within one bus cycle of where it occurs. A wrong byte counter shows as a missing or extra data byte on the log or the read stream before the done pulse. A broken wait or status path shows as a wrong done_code, or as a timeout, within the busy window. A bad cycle-timing counter changes the measured strobe width or setup gap on the very cycle it affects.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int PAGE_BYTES = 2112;
    localparam int RB_GUARD   = 4;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_JUMP  = 3'd2,
        OP_COMMIT= 3'd3,
        OP_ERASE = 3'd4,
        OP_COPY  = 3'd5,
        OP_STAT  = 3'd6,
        OP_BAD   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        DC_PASS = 2'd0,
        DC_FAIL = 2'd1,
        DC_TMO  = 2'd2,
        DC_REJ  = 2'd3
    } dcode_e;

    typedef enum logic [1:0] { CK_CMD, CK_ADDR, CK_WR, CK_RD } cyc_e;

    typedef enum logic [2:0] { SK_CMD, SK_ADDR, SK_WR, SK_RD, SK_WAIT, SK_STAT, SK_END } step_e;

    typedef enum logic [2:0] { AS_CR, AS_C, AS_R, AS_ZS, AS_ZD } asel_e;

    typedef struct packed {
        step_e      kind;
        logic [7:0] cmd;
        asel_e      asel;
    } step_t;

    function automatic step_t mk(step_e k, logic [7:0] c, asel_e a);
        step_t s;
        s.kind = k;
        s.cmd  = c;
        s.asel = a;
        return s;
    endfunction

    // Ordered step list of each operation
    function automatic step_t plan(op_e op, logic [3:0] st);
        step_t s;
        s = mk(SK_END, 8'h00, AS_CR);
        case (op)
            OP_READ: case (st)
                4'd0: s = mk(SK_CMD,  8'h00, AS_CR);
                4'd1: s = mk(SK_ADDR, 8'h00, AS_CR);
                4'd2: s = mk(SK_CMD,  8'h30, AS_CR);
                4'd3: s = mk(SK_WAIT, 8'h00, AS_CR);
                4'd4: s = mk(SK_RD,   8'h00, AS_CR);
                default: ;
            endcase
            OP_LOAD: case (st)
                4'd0: s = mk(SK_CMD,  8'h80, AS_CR);
                4'd1: s = mk(SK_ADDR, 8'h00, AS_CR);
                4'd2: s = mk(SK_WR,   8'h00, AS_CR);
                default: ;
            endcase
            OP_JUMP: case (st)
                4'd0: s = mk(SK_CMD,  8'h85, AS_C);
                4'd1: s = mk(SK_ADDR, 8'h00, AS_C);
                4'd2: s = mk(SK_WR,   8'h00, AS_C);
                default: ;
            endcase
            OP_COMMIT: case (st)
                4'd0: s = mk(SK_CMD,  8'h10, AS_CR);
                4'd1: s = mk(SK_WAIT, 8'h00, AS_CR);
                4'd2: s = mk(SK_CMD,  8'h70, AS_CR);
                4'd3: s = mk(SK_STAT, 8'h00, AS_CR);
                default: ;
            endcase
            OP_ERASE: case (st)
                4'd0: s = mk(SK_CMD,  8'h60, AS_R);
                4'd1: s = mk(SK_ADDR, 8'h00, AS_R);
                4'd2: s = mk(SK_CMD,  8'hD0, AS_R);
                4'd3: s = mk(SK_WAIT, 8'h00, AS_R);
                4'd4: s = mk(SK_CMD,  8'h70, AS_R);
                4'd5: s = mk(SK_STAT, 8'h00, AS_R);
                default: ;
            endcase
            OP_COPY: case (st)
                4'd0: s = mk(SK_CMD,  8'h00, AS_ZS);
                4'd1: s = mk(SK_ADDR, 8'h00, AS_ZS);
                4'd2: s = mk(SK_CMD,  8'h35, AS_ZS);
                4'd3: s = mk(SK_WAIT, 8'h00, AS_ZS);
                4'd4: s = mk(SK_CMD,  8'h85, AS_ZD);
                4'd5: s = mk(SK_ADDR, 8'h00, AS_ZD);
                4'd6: s = mk(SK_CMD,  8'h10, AS_ZD);
                4'd7: s = mk(SK_WAIT, 8'h00, AS_ZD);
                4'd8: s = mk(SK_CMD,  8'h70, AS_ZD);
                4'd9: s = mk(SK_STAT, 8'h00, AS_ZD);
                default: ;
            endcase
            OP_STAT: case (st)
                4'd0: s = mk(SK_CMD,  8'h70, AS_CR);
                4'd1: s = mk(SK_STAT, 8'h00, AS_CR);
                default: ;
            endcase
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nand_seq_sync.sv
module nand_seq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 2'b00;
        else        sh_q <= {sh_q[0], d};
    end

    assign q = sh_q[1];
endmodule

// File: rtl/nand_seq_cycle.sv
module nand_seq_cycle
    import nand_seq_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  cyc_e          kind,
    input  logic [7:0]    byte_in,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_pulse,
    input  logic [7:0]    io_in,
    output logic          cyc_done,
    output logic [7:0]    rbyte,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic [7:0]    io_out,
    output logic          io_oe
);
    typedef enum logic [1:0] { ES_IDLE, ES_SETUP, ES_PULSE, ES_HOLD } est_e;

    typedef struct packed {
        est_e          st;
        logic [TW-1:0] cnt;
        cyc_e          kind;
        logic [7:0]    data;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d        = q;
        cyc_done = 1'b0;
        case (q.st)
            ES_IDLE: if (start) begin
                d.st   = ES_SETUP;
                d.cnt  = cfg_setup;
                d.kind = kind;
                d.data = byte_in;
            end
            ES_SETUP: if (q.cnt == '0) begin
                d.st  = ES_PULSE;
                d.cnt = cfg_pulse;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
            ES_PULSE: if (q.cnt == '0) begin
                d.st = ES_HOLD;
                if (q.kind == CK_RD) d.data = io_in;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
            default: begin
                cyc_done = 1'b1;
                d.st     = ES_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ES_IDLE, cnt: '0, kind: CK_CMD, data: 8'h00};
        else        q <= d;
    end

    logic act;
    assign act    = (q.st != ES_IDLE);
    assign cle    = act && (q.kind == CK_CMD);
    assign ale    = act && (q.kind == CK_ADDR);
    assign we_n   = !((q.st == ES_PULSE) && (q.kind != CK_RD));
    assign re_n   = !((q.st == ES_PULSE) && (q.kind == CK_RD));
    assign io_oe  = act && (q.kind != CK_RD);
    assign io_out = q.data;
    assign rbyte  = q.data;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n)); // R12
    AST_LATCH_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale)); // R12
    AST_IO_STABLE:   assert property (@(posedge clk) disable iff (!rst_n) (!we_n && $past(!we_n)) |-> $stable(io_out)); // R12
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int ROW_W = 16,
    parameter int COL_W = 12,
    parameter int TW    = 4,
    parameter int TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [ROW_W-1:0] req_dst_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [COL_W-1:0] req_len,
    input  logic [TW-1:0]    cfg_setup,
    input  logic [TW-1:0]    cfg_pulse,
    input  logic [TO_W-1:0]  cfg_timeout,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             done,
    output logic [1:0]       done_code,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(PAGE_BYTES - 1);
    localparam logic [TO_W-1:0]  GUARD    = TO_W'(RB_GUARD);

    typedef enum logic [1:0] { PH_IDLE, PH_RUN, PH_DONE } ph_e;

    typedef struct packed {
        ph_e              ph;
        op_e              op;
        logic [3:0]       stage;
        logic [ROW_W-1:0] row;
        logic [ROW_W-1:0] dst;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] len;
        logic [COL_W-1:0] cnt;
        logic             busy;
        logic [TO_W-1:0]  wcnt;
        logic [7:0]       stat;
        dcode_e           code;
        logic             open;
        logic [7:0]       rdat;
        logic             rvld;
    } seq_t;

    seq_t q, d;

    logic       eng_start, eng_done, rb_s, bad;
    cyc_e       eng_kind;
    logic [7:0] eng_byte, eng_rbyte;
    step_t      stp;

    function automatic logic [7:0] abyte(asel_e a, logic [COL_W-1:0] i,
                                         logic [COL_W-1:0] c, logic [ROW_W-1:0] r,
                                         logic [ROW_W-1:0] ds);
        logic [31:0] c32, r32, d32;
        c32 = 32'(c);
        r32 = 32'(r);
        d32 = 32'(ds);
        case (a)
            AS_C:  return (i == 0) ? c32[7:0] : {4'h0, c32[11:8]};
            AS_R:  return (i == 0) ? r32[7:0] : r32[15:8];
            AS_ZS: return (i < 2) ? 8'h00 : ((i == 2) ? r32[7:0] : r32[15:8]);
            AS_ZD: return (i < 2) ? 8'h00 : ((i == 2) ? d32[7:0] : d32[15:8]);
            default: case (i)
                0: return c32[7:0];
                1: return {4'h0, c32[11:8]};
                2: return r32[7:0];
                default: return r32[15:8];
            endcase
        endcase
    endfunction

    always_comb begin
        d         = q;
        req_ready = 1'b0;
        wr_ready  = 1'b0;
        eng_start = 1'b0;
        eng_kind  = CK_CMD;
        eng_byte  = 8'h00;
        done      = 1'b0;
        bad       = 1'b0;
        stp       = plan(q.op, q.stage);
        if (q.rvld && rd_ready) d.rvld = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                req_ready = 1'b1;
                case (op_e'(req_op))
                    OP_READ, OP_LOAD: bad = (req_col > COL_LAST);
                    OP_JUMP:          bad = (req_col > COL_LAST) || !q.open;
                    OP_COMMIT:        bad = !q.open;
                    OP_ERASE, OP_COPY, OP_STAT: bad = 1'b0;
                    default:          bad = 1'b1;
                endcase
                if (req_valid) begin
                    d.op    = op_e'(req_op);
                    d.row   = req_row;
                    d.dst   = req_dst_row;
                    d.col   = req_col;
                    d.len   = req_len;
                    d.stage = '0;
                    d.cnt   = '0;
                    d.busy  = 1'b0;
                    d.wcnt  = '0;
                    if (bad) begin
                        d.ph   = PH_DONE;
                        d.code = DC_REJ;
                    end else begin
                        d.ph = PH_RUN;
                        if (op_e'(req_op) == OP_LOAD)      d.open = 1'b1;
                        else if (op_e'(req_op) != OP_JUMP) d.open = 1'b0;
                    end
                end
            end
            PH_RUN: case (stp.kind)
                SK_CMD, SK_ADDR: begin
                    eng_kind = (stp.kind == SK_CMD) ? CK_CMD : CK_ADDR;
                    eng_byte = (stp.kind == SK_CMD) ? stp.cmd : abyte(stp.asel, q.cnt, q.col, q.row, q.dst);
                    if (!q.busy) begin
                        eng_start = 1'b1;
                        d.busy    = 1'b1;
                    end else if (eng_done) begin
                        d.busy = 1'b0;
                        if (stp.kind == SK_CMD ||
                            q.cnt == (((stp.asel == AS_C) || (stp.asel == AS_R)) ? COL_W'(1) : COL_W'(3))) begin
                            d.stage = q.stage + 1'b1;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                SK_WR: begin
                    eng_kind = CK_WR;
                    eng_byte = wr_data;
                    if (q.busy) begin
                        if (eng_done) begin
                            d.busy = 1'b0;
                            d.cnt  = q.cnt + 1'b1;
                        end
                    end else if (q.cnt == q.len) begin
                        d.stage = q.stage + 1'b1;
                        d.cnt   = '0;
                    end else if (wr_valid) begin
                        wr_ready  = 1'b1;
                        eng_start = 1'b1;
                        d.busy    = 1'b1;
                    end
                end
                SK_RD, SK_STAT: begin
                    eng_kind = CK_RD;
                    if (q.busy) begin
                        if (eng_done) begin
                            d.busy = 1'b0;
                            if (stp.kind == SK_STAT) begin
                                d.stat  = eng_rbyte;
                                d.stage = q.stage + 1'b1;
                                if (q.op == OP_STAT) begin
                                    d.rdat = eng_rbyte;
                                    d.rvld = 1'b1;
                                end
                            end else begin
                                d.rdat = eng_rbyte;
                                d.rvld = 1'b1;
                                d.cnt  = q.cnt + 1'b1;
                            end
                        end
                    end else if (stp.kind == SK_RD && q.cnt == q.len) begin
                        if (!q.rvld) begin
                            d.stage = q.stage + 1'b1;
                            d.cnt   = '0;
                        end
                    end else if (!q.rvld) begin
                        eng_start = 1'b1;
                        d.busy    = 1'b1;
                    end
                end
                SK_WAIT: begin
                    d.wcnt = q.wcnt + 1'b1;
                    if (q.wcnt >= GUARD && rb_s) begin
                        d.stage = q.stage + 1'b1;
                        d.wcnt  = '0;
                    end else if (q.wcnt >= cfg_timeout) begin
                        d.ph   = PH_DONE;
                        d.code = DC_TMO;
                        d.wcnt = '0;
                    end
                end
                default: if (!q.rvld) begin
                    d.ph   = PH_DONE;
                    d.code = ((q.op == OP_COMMIT || q.op == OP_ERASE || q.op == OP_COPY) && q.stat[0])
                             ? DC_FAIL : DC_PASS;
                end
            endcase
            default: begin
                done = 1'b1;
                d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, op: OP_READ, stage: '0, row: '0, dst: '0, col: '0, len: '0,
                   cnt: '0, busy: 1'b0, wcnt: '0, stat: 8'h00, code: DC_PASS, open: 1'b0,
                   rdat: 8'h00, rvld: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign done_code = q.code;
    assign rd_data   = q.rdat;
    assign rd_valid  = q.rvld;
    assign nand_ce_n = (q.ph != PH_RUN);

    nand_seq_sync u_rb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nand_rb),
        .q     (rb_s)
    );

    nand_seq_cycle #(.TW(TW)) u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .kind      (eng_kind),
        .byte_in   (eng_byte),
        .cfg_setup (cfg_setup),
        .cfg_pulse (cfg_pulse),
        .io_in     (nand_io_in),
        .cyc_done  (eng_done),
        .rbyte     (eng_rbyte),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .io_out    (nand_io_out),
        .io_oe     (nand_io_oe)
    );

    AST_IDLE_BUS:   assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (nand_ce_n && nand_we_n && nand_re_n)); // R13
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_RD_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R2
    AST_WR_IN_OP:   assert property (@(posedge clk) disable iff (!rst_n) wr_ready |-> !nand_ce_n); // R3
endmodule

// File: tb/nand_seq_test.sv
module nand_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [15:0] req_row = 16'h0, req_dst_row = 16'h0;
    logic [11:0] req_col = 12'h0, req_len = 12'h0;
    logic [3:0]  cfg_setup = 4'd2, cfg_pulse = 4'd3;
    logic [15:0] cfg_timeout = 16'd2000;
    logic [7:0]  wr_data;
    logic        wr_valid = 1'b1, wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid, rd_ready = 1'b1;
    logic        done;
    logic [1:0]  done_code;
    logic        ce_n, cle, ale, we_n, re_n, io_oe, rb;
    logic [7:0]  io_out, io_in;

    always #10 clk = ~clk;

    nand_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_row(req_row), .req_dst_row(req_dst_row), .req_col(req_col),
        .req_len(req_len), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_timeout(cfg_timeout),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .done(done), .done_code(done_code),
        .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
        .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_io_in(io_in), .nand_rb(rb)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [9:0] lg [0:63];
    logic [9:0] ex [0:63];
    int         lg_n = 0, ex_n = 0;
    logic [7:0] src [0:15];
    int         wr_idx = 0;
    logic [7:0] rx [0:15];
    int         rx_n = 0;
    logic [11:0] rd_ptr = 12'h0;
    int         addr_n = 0;
    bit         stat_mode = 1'b0;
    logic [7:0] stat_byte = 8'hE0;
    int         busy_left = 0, busy_len = 20;
    logic       we_p = 1'b1, re_p = 1'b1;
    int         we_low = 0, re_low = 0, pre = 0, tim_err = 0, strobes = 0, ce_idle_err = 0;
    bit         ce_seen = 1'b0;
    int         done_cnt = 0;
    logic [1:0] last_code = 2'd0;

    assign rb      = (busy_left == 0);
    assign io_in   = stat_mode ? stat_byte : (rd_ptr[7:0] ^ 8'h5A);
    assign wr_data = src[wr_idx[3:0]];

    always @(negedge clk) begin
        if (!ce_n) ce_seen = 1'b1;
        if (req_ready && !ce_n) ce_idle_err++;
        if (busy_left > 0) busy_left--;
        if (we_p == 1'b0 && we_n == 1'b1 && !ce_n) begin
            if (lg_n < 64) lg[lg_n] = {cle ? 2'd1 : (ale ? 2'd2 : 2'd3), io_out};
            lg_n++;
            if (cle) begin
                addr_n = 0;
                if (io_out == 8'h70) stat_mode = 1'b1;
                if (io_out == 8'h00) stat_mode = 1'b0;
                if (io_out == 8'h30 || io_out == 8'h10 || io_out == 8'hD0 || io_out == 8'h35)
                    busy_left = busy_len;
            end else if (ale) begin
                if (addr_n == 0) rd_ptr[7:0] = io_out;
                if (addr_n == 1) rd_ptr[11:8] = io_out[3:0];
                addr_n++;
            end
        end
        if (re_p == 1'b0 && re_n == 1'b1 && !stat_mode) rd_ptr = rd_ptr + 1'b1;
        // timing monitor (R12)
        if (!we_n) begin
            if (we_p) begin
                strobes++;
                if (pre != int'(cfg_setup) + 1) tim_err++;
            end
            we_low++;
        end else if (!we_p) begin
            if (we_low != int'(cfg_pulse) + 1) tim_err++;
            we_low = 0;
        end
        if (!re_n) re_low++;
        else if (!re_p) begin
            strobes++;
            if (re_low != int'(cfg_pulse) + 1) tim_err++;
            re_low = 0;
        end
        if ((cle || ale || io_oe) && we_n && re_n) pre++;
        else pre = 0;
        if (!we_n && !re_n) tim_err++;
        we_p = we_n;
        re_p = re_n;
    end

    always @(posedge clk) begin
        if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
        if (rd_valid && rd_ready) begin
            if (rx_n < 16) rx[rx_n] <= rd_data;
            rx_n <= rx_n + 1;
        end
        if (done) begin
            done_cnt  <= done_cnt + 1;
            last_code <= done_code;
        end
    end

    // ---------------- helpers ----------------
    task automatic clr();
        lg_n = 0; ex_n = 0; rx_n = 0; ce_seen = 1'b0;
    endtask

    task automatic exp(input logic [1:0] k, input logic [7:0] b);
        ex[ex_n] = {k, b};
        ex_n++;
    endtask

    task automatic cmp_log(input string tag);
        int bad_i;
        bad_i = -1;
        check(lg_n == ex_n, tag, lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++)
            if (bad_i < 0 && lg[i] != ex[i]) bad_i = i;
        if (bad_i >= 0) check(1'b0, tag, int'(lg[bad_i]), int'(ex[bad_i]));
        else check(1'b1, tag, 0, 0);
    endtask

    task automatic run(input logic [2:0] op, input logic [15:0] row, input logic [15:0] dst,
                       input logic [11:0] col, input logic [11:0] len);
        int start_cnt;
        start_cnt = done_cnt;
        @(negedge clk);
        req_op = op; req_row = row; req_dst_row = dst; req_col = col; req_len = len;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 20000 && done_cnt == start_cnt; i++) @(negedge clk);
        @(negedge clk);
        if (done_cnt == start_cnt) check(1'b0, "no done", 0, 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(ce_n && we_n && re_n, "R1 strobes idle", {ce_n, we_n, re_n}, 7);
        check(!cle && !ale && !io_oe, "R1 latches idle", {cle, ale, io_oe}, 0);
        check(req_ready && !done, "R1 ready", {req_ready, done}, 2);
    endtask

    task automatic t_read();
        clr();
        run(3'd0, 16'h1234, 16'h0, 12'h7F8, 12'd4);
        exp(1, 8'h00); exp(2, 8'hF8); exp(2, 8'h07); exp(2, 8'h34); exp(2, 8'h12); exp(1, 8'h30);
        cmp_log("R2 read sequence");
        check(rx_n == 4, "R2 read count", rx_n, 4);
        for (int i = 0; i < 4; i++)
            check(rx[i] == ((8'hF8 + 8'(i)) ^ 8'h5A), "R2 read data", rx[i], (8'hF8 + 8'(i)) ^ 8'h5A);
        check(last_code == 2'd0, "R9 read pass", last_code, 0);
    endtask

    task automatic t_program();
        clr();
        src[0] = 8'h11; src[1] = 8'h22; src[2] = 8'h33; src[3] = 8'h44; src[4] = 8'h55;
        wr_idx = 0;
        run(3'd1, 16'h0042, 16'h0, 12'h010, 12'd3);
        check(last_code == 2'd0, "R3 load pass", last_code, 0);
        run(3'd2, 16'h0, 16'h0, 12'h123, 12'd2);
        check(last_code == 2'd0, "R4 jump pass", last_code, 0);
        run(3'd3, 16'h0, 16'h0, 12'h0, 12'd0);
        check(last_code == 2'd0, "R5 commit pass", last_code, 0);
        exp(1, 8'h80); exp(2, 8'h10); exp(2, 8'h00); exp(2, 8'h42); exp(2, 8'h00);
        exp(3, 8'h11); exp(3, 8'h22); exp(3, 8'h33);
        exp(1, 8'h85); exp(2, 8'h23); exp(2, 8'h01); exp(3, 8'h44); exp(3, 8'h55);
        exp(1, 8'h10); exp(1, 8'h70);
        cmp_log("R3 R4 R5 program sequence");
        clr();
        run(3'd2, 16'h0, 16'h0, 12'h0, 12'd1);
        check(last_code == 2'd3 && lg_n == 0, "R4 jump after commit rejected", last_code, 3);
        run(3'd3, 16'h0, 16'h0, 12'h0, 12'd0);
        check(last_code == 2'd3 && lg_n == 0, "R5 commit without load rejected", last_code, 3);
    endtask

    task automatic t_erase_fail();
        clr();
        stat_byte = 8'hE1;
        run(3'd4, 16'hA5C3, 16'h0, 12'h0, 12'd0);
        exp(1, 8'h60); exp(2, 8'hC3); exp(2, 8'hA5); exp(1, 8'hD0); exp(1, 8'h70);
        cmp_log("R6 erase sequence");
        check(last_code == 2'd1, "R9 R6 erase fail code", last_code, 1);
        stat_byte = 8'hE0;
    endtask

    task automatic t_copy();
        clr();
        cfg_setup = 4'd1; cfg_pulse = 4'd1;
        run(3'd5, 16'h0305, 16'h0306, 12'h0, 12'd0);
        exp(1, 8'h00); exp(2, 8'h00); exp(2, 8'h00); exp(2, 8'h05); exp(2, 8'h03); exp(1, 8'h35);
        exp(1, 8'h85); exp(2, 8'h00); exp(2, 8'h00); exp(2, 8'h06); exp(2, 8'h03); exp(1, 8'h10);
        exp(1, 8'h70);
        cmp_log("R7 copy-back sequence");
        check(last_code == 2'd0, "R7 copy-back pass", last_code, 0);
    endtask

    task automatic t_status_then_read();
        clr();
        cfg_setup = 4'd0; cfg_pulse = 4'd0;
        run(3'd6, 16'h0, 16'h0, 12'h0, 12'd0);
        exp(1, 8'h70);
        cmp_log("R8 status sequence");
        check(rx_n == 1 && rx[0] == 8'hE0, "R8 status byte", rx[0], 8'hE0);
        clr();
        run(3'd0, 16'h0000, 16'h0, 12'h000, 12'd2);
        check(lg_n > 0 && lg[0] == {2'd1, 8'h00}, "R8 read after status starts 00h", lg[0], 10'h100);
        check(rx_n == 2 && rx[0] == 8'h5A && rx[1] == 8'h5B, "R8 read data after status", rx[1], 8'h5B);
        cfg_setup = 4'd2; cfg_pulse = 4'd3;
    endtask

    task automatic t_reject();
        clr();
        run(3'd0, 16'h0001, 16'h0, 12'd2112, 12'd1);
        check(last_code == 2'd3, "R10 column 2112 rejected", last_code, 3);
        check(lg_n == 0 && !ce_seen, "R10 no bus activity", lg_n, 0);
        clr();
        run(3'd7, 16'h0001, 16'h0, 12'd0, 12'd0);
        check(last_code == 2'd3 && !ce_seen, "R10 op 7 rejected", last_code, 3);
        clr();
        run(3'd0, 16'h0001, 16'h0, 12'd2111, 12'd1);
        check(last_code == 2'd0 && rx_n == 1 && rx[0] == 8'h65, "R10 column 2111 accepted", rx[0], 8'h65);
    endtask

    task automatic t_timeout();
        clr();
        cfg_timeout = 16'd40;
        busy_len = 1000000;
        run(3'd4, 16'h0009, 16'h0, 12'h0, 12'd0);
        check(last_code == 2'd2, "R11 timeout code", last_code, 2);
        check(ce_n == 1'b1, "R11 CE released", ce_n, 1);
        busy_left = 0;
        busy_len = 20;
        cfg_timeout = 16'd2000;
    endtask

    // ---------------- main ----------------
    int  cyc = 0;
    bit  finished = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_read();
        t_program();
        t_erase_fail();
        t_copy();
        t_status_then_read();
        t_reject();
        t_timeout();
        check(strobes > 50 && tim_err == 0, "R12 strobe timing", tim_err, 0);
        check(ce_idle_err == 0, "R13 CE high when idle", ce_idle_err, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule